// File: doc/BRIEF.md
# Link Error Event Counter Bank

This block keeps a small set of event counters for one serial storage port and hands them to the command layer as a log page. Four single-cycle event inputs report link trouble: a received frame with a bad CRC, a received frame with some other fault, the link leaving the ready state, and a signature register frame sent after a link reset. Each pulse adds one to its own counter. The counter holds at its all-ones maximum and does not wrap.

When the command layer asks for the page, the block copies every counter value at that edge. It then streams exactly 256 sixteen-bit words. Each counter entry starts with an identifier word. Bit 15 of that word marks a vendor-specific counter, and bits 14:12 give the number of value words that follow. The value words come least-significant word first. A zero identifier ends the list, and zero words fill the rest of the page. A done pulse follows the last word.

All counters return to zero on a self-test activation pulse. They also return to zero right after a page request that has the clear flag set; that page still carries the values from before the clear. An event that coincides with a clear is counted after the clear.

Top module: `link_evt_log`

## Requirements
- R1: After reset, `page_vld` and `page_done` are low, and a page read before any event reports every counter value as zero.
- R2: A pulse on one event input adds exactly one to that event's counter and to no other counter. Pulses on several inputs in the same cycle each add one to their own counter.
- R3: A counter that has reached its all-ones maximum stays at that maximum when more events arrive. The CRC-error counter is 16 bits, so its value saturates at FFFFh.
- R4: Page words 0 to 9 hold the following entries in this order:
  - word 0: identifier 1001h, then one value word for the CRC-error counter;
  - word 2: identifier 1002h, then one value word for the other-fault counter;
  - word 4: identifier 2003h, then two value words for the link-drop counter;
  - word 7: identifier 2004h, then two value words for the signature counter.
  
  Multi-word values are sent least-significant word first.
- R5: In every identifier word, bits 14:12 hold the number of value words that follow it (a code from 1 to 4). Bit 15 is zero for all four counters, because none of them is vendor-specific.
- R6: A request accepted while idle starts the page on the next cycle. `page_vld` then stays high for exactly 256 consecutive cycles. Word 10 is the zero terminator, and words 11 to 255 are zero.
- R7: `page_done` is high for exactly one cycle, in the cycle right after the last page word, and `page_vld` is low in that cycle.
- R8: A request that arrives while a page is streaming is ignored. It neither restarts nor extends the page.
- R9: A request with `rd_clr` high returns the counter values as they were before the request, and then sets all counters to zero. A request with `rd_clr` low leaves the counters unchanged.
- R10: A `selftest_clr` pulse sets all counters to zero.
- R11: An event in the same cycle as a clear (self-test, or a request with `rd_clr` high) leaves its counter at one.
- R12: The page reflects the counters at the edge where the request is accepted. Events that arrive during streaming are counted but do not change the page in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_crc | input | 1 | CRC error seen in a received frame |
| ev_frame_err | input | 1 | Other (non-CRC) error in a received frame |
| ev_link_drop | input | 1 | Link went from ready to not ready |
| ev_sig_sent | input | 1 | Signature frame sent after a link reset |
| selftest_clr | input | 1 | Self-test activation pulse; clears all counters |
| rd_req | input | 1 | Request to stream the log page |
| rd_clr | input | 1 | With `rd_req`, clear all counters after the snapshot |
| page_vld | output | 1 | A page word is valid this cycle |
| page_word | output | 16 | Page word |
| page_done | output | 1 | One-cycle pulse after the last page word |

## Verification
Single-input bursts of different lengths on each event input show whether every count reaches its own counter and its own page position. Bursts on several inputs at once show whether simultaneous events are kept apart. Pulses that coincide with a self-test pulse or a clearing request separate "clear, then count" from "count, then clear". Events and a second request sent while a page streams show whether the page reflects the snapshot and whether the stream can be restarted. A long burst on the 16-bit counter, next to an equally long burst on a 32-bit counter, tells saturation apart from wrap-around and from truncation of a wider counter.

// File: rtl/link_evt_pkg.sv
package link_evt_pkg;
    localparam int NCTR       = 4;
    localparam int WORD_W     = 16;
    localparam int PAGE_WORDS = 256;

    // identifier: [15] vendor flag, [14:12] value word count, [11:0] event code
    localparam logic [15:0] CTR_ID [NCTR] = '{16'h1001, 16'h1002, 16'h2003, 16'h2004};

    function automatic int id_words(input logic [15:0] id);
        return int'(id[14:12]);
    endfunction

    // bit offset of counter i inside the flat value vector
    function automatic int bit_off(input int i);
        int s = 0;
        for (int j = 0; j < i; j++) s += WORD_W * id_words(CTR_ID[j]);
        return s;
    endfunction

    // page position of the identifier word of counter i
    function automatic int word_base(input int i);
        int s = 0;
        for (int j = 0; j < i; j++) s += 1 + id_words(CTR_ID[j]);
        return s;
    endfunction

    localparam int TOT_BITS   = bit_off(NCTR);
    localparam int LIST_WORDS = word_base(NCTR);
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev,
    input  logic         clr,
    output logic [W-1:0] value
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [W-1:0] base;

    always_comb begin
        st_d = st_q;
        base = clr ? '0 : st_q.cnt;
        st_d.cnt = base;
        if (ev && (base != {W{1'b1}})) st_d.cnt = base + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.cnt;

    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == {W{1'b1}}) && !clr |=> st_q.cnt == {W{1'b1}});
    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev && !clr && (st_q.cnt != {W{1'b1}}) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);
    // R11
    clr_then_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.cnt == W'($past(ev)));
endmodule

// File: rtl/page_streamer.sv
module page_streamer
    import link_evt_pkg::*;
#(
    parameter int NW = PAGE_WORDS,
    parameter int TB = TOT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [TB-1:0]     snap_in,
    output logic              accept,
    output logic              vld,
    output logic [WORD_W-1:0] word,
    output logic              done
);
    localparam int IDX_W = $clog2(NW);
    localparam int LW_W  = $clog2(LIST_WORDS + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NW - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [TB-1:0]    snap;
        logic             done;
    } str_st_t;

    str_st_t st_d, st_q;
    logic [WORD_W-1:0] pick [LIST_WORDS];

    for (genvar i = 0; i < NCTR; i++) begin : g_ent
        localparam int NWI = id_words(CTR_ID[i]);
        localparam int WB  = word_base(i);
        localparam int BO  = bit_off(i);
        assign pick[WB] = CTR_ID[i];
        for (genvar w = 0; w < NWI; w++) begin : g_val
            assign pick[WB + 1 + w] = st_q.snap[BO + WORD_W*w +: WORD_W];
        end
    end

    assign accept = req && !st_q.busy;

    always_comb begin
        st_d = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.snap = snap_in;
            end
        end else if (st_q.idx == LAST) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word = '0;
        if (st_q.busy && (int'(st_q.idx) < LIST_WORDS))
            word = pick[st_q.idx[LW_W-1:0]];
    end

    assign vld  = st_q.busy;
    assign done = st_q.done;

    // R6
    start_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && !st_q.busy |=> st_q.busy && (st_q.idx == '0));
    // R8
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && (st_q.idx != LAST) |=> st_q.busy && (st_q.idx == $past(st_q.idx) + 1'b1));
    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy && $past(st_q.busy) && ($past(st_q.idx) == LAST));
    // R12
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && (st_q.idx != LAST) |=> $stable(st_q.snap));
endmodule

// File: rtl/link_evt_log.sv
module link_evt_log
    import link_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_crc,
    input  logic        ev_frame_err,
    input  logic        ev_link_drop,
    input  logic        ev_sig_sent,
    input  logic        selftest_clr,
    input  logic        rd_req,
    input  logic        rd_clr,
    output logic        page_vld,
    output logic [15:0] page_word,
    output logic        page_done
);
    logic [NCTR-1:0]     ev_vec;
    logic [TOT_BITS-1:0] live_vec;
    logic                accept;
    logic                clr_all;

    assign ev_vec  = {ev_sig_sent, ev_link_drop, ev_frame_err, ev_crc};
    assign clr_all = selftest_clr || (accept && rd_clr);

    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
        localparam int CW = WORD_W * id_words(CTR_ID[i]);
        evt_counter #(.W(CW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev_vec[i]),
            .clr   (clr_all),
            .value (live_vec[bit_off(i) +: CW])
        );
    end

    page_streamer #(.NW(PAGE_WORDS), .TB(TOT_BITS)) u_str (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (rd_req),
        .snap_in (live_vec),
        .accept  (accept),
        .vld     (page_vld),
        .word    (page_word),
        .done    (page_done)
    );

    // R7
    done_not_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |-> !page_vld);
    // R9
    rdclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !page_vld && rd_clr && (ev_vec == '0) |=> live_vec == '0);
endmodule

// File: tb/tb_link_evt_log.sv
module tb_link_evt_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ev = '0;
    logic        selftest_clr = 1'b0;
    logic        rd_req = 1'b0;
    logic        rd_clr = 1'b0;
    logic        page_vld;
    logic [15:0] page_word;
    logic        page_done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    localparam logic [15:0] BID [4] = '{16'h1001, 16'h1002, 16'h2003, 16'h2004};
    localparam int          BNW [4] = '{1, 1, 2, 2};

    logic [63:0] exp_v [4];
    logic [15:0] got [256];
    logic [15:0] want [256];

    always #10 clk = ~clk;

    link_evt_log dut (
        .clk(clk), .rst_n(rst_n),
        .ev_crc(ev[0]), .ev_frame_err(ev[1]), .ev_link_drop(ev[2]), .ev_sig_sent(ev[3]),
        .selftest_clr(selftest_clr), .rd_req(rd_req), .rd_clr(rd_clr),
        .page_vld(page_vld), .page_word(page_word), .page_done(page_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] cmax(input int i);
        return (64'd1 << (16 * BNW[i])) - 64'd1;
    endfunction

    task automatic model_add(input logic [3:0] m);
        for (int i = 0; i < 4; i++)
            if (m[i] && exp_v[i] != cmax(i)) exp_v[i] = exp_v[i] + 64'd1;
    endtask

    task automatic build_want();
        int p = 0;
        for (int k = 0; k < 256; k++) want[k] = '0;
        for (int i = 0; i < 4; i++) begin
            want[p] = BID[i]; p++;
            for (int w = 0; w < BNW[i]; w++) begin
                want[p] = exp_v[i][16*w +: 16]; p++;
            end
        end
    endtask

    task automatic pulse(input logic [3:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ev = m;
            model_add(m);
        end
        @(negedge clk); ev = '0;
    endtask

    task automatic selftest(input logic [3:0] m);
        @(negedge clk); selftest_clr = 1'b1; ev = m;
        for (int i = 0; i < 4; i++) exp_v[i] = '0;
        model_add(m);
        @(negedge clk); selftest_clr = 1'b0; ev = '0;
    endtask

    // read a page; checks contents, validity window and done pulse
    task automatic read_page(input bit clr, input logic [3:0] req_ev, input logic [3:0] s_ev,
                             input int s_cyc, input bit poke, input string tag);
        int vld_bad = 0;
        int first_bad = -1;
        build_want();
        @(negedge clk); rd_req = 1'b1; rd_clr = clr; ev = req_ev;
        if (clr) for (int i = 0; i < 4; i++) exp_v[i] = '0;
        model_add(req_ev);
        @(negedge clk); rd_req = 1'b0; rd_clr = 1'b0; ev = '0;
        for (int k = 0; k < 256; k++) begin
            got[k] = page_word;
            if (page_vld !== 1'b1 || page_done !== 1'b0) vld_bad++;
            ev = (k < s_cyc) ? s_ev : 4'b0;
            if (k < s_cyc) model_add(s_ev);
            rd_req = poke && (k == 5);
            @(negedge clk);
        end
        ev = '0; rd_req = 1'b0;
        for (int k = 0; k < 256; k++)
            if (first_bad < 0 && got[k] !== want[k]) first_bad = k;
        chk(first_bad < 0, {tag, " page words"},
            (first_bad < 0) ? 64'd0 : {48'd0, got[first_bad]},
            (first_bad < 0) ? 64'd0 : {48'd0, want[first_bad]});
        chk(vld_bad == 0, "R6 page_vld high for 256 cycles", 64'(vld_bad), 64'd0);
        chk(page_vld === 1'b0 && page_done === 1'b1, "R7 done after last word",
            {62'd0, page_vld, page_done}, 64'd1);
        @(negedge clk);
        chk(page_vld === 1'b0 && page_done === 1'b0, "R7/R8 done single cycle, no restart",
            {62'd0, page_vld, page_done}, 64'd0);
    endtask

    task automatic t_reset();
        chk(page_vld === 1'b0 && page_done === 1'b0, "R1 outputs idle after reset",
            {62'd0, page_vld, page_done}, 64'd0);
        read_page(1'b0, 4'b0, 4'b0, 0, 1'b0, "R1 zero counters");
    endtask

    task automatic t_single();
        pulse(4'b0001, 3); pulse(4'b0010, 5); pulse(4'b0100, 7); pulse(4'b1000, 2);
        read_page(1'b0, 4'b0, 4'b0, 0, 1'b0, "R2 R4 single-input counts");
        begin
            int p = 0; int guard = 0; bit ok = 1'b1;
            while (got[p] != 16'h0 && guard < 8) begin
                if (got[p][15] != 1'b0 || got[p][14:12] == 3'd0 || got[p][14:12] > 3'd4) ok = 1'b0;
                p = p + 1 + int'(got[p][14:12]);
                guard++;
            end
            chk(ok && p == 10, "R5 identifier width codes walk to terminator", 64'(p), 64'd10);
        end
        for (int k = 10; k < 256; k++)
            if (got[k] != 16'h0) begin
                chk(1'b0, "R6 terminator and padding", {48'd0, got[k]}, 64'd0);
                break;
            end
        read_page(1'b0, 4'b0, 4'b0, 0, 1'b0, "R9 no-clear read leaves counts");
    endtask

    task automatic t_multi();
        pulse(4'b1111, 4); pulse(4'b0101, 3);
        read_page(1'b0, 4'b0, 4'b0, 0, 1'b0, "R2 simultaneous events");
    endtask

    task automatic t_readclr();
        read_page(1'b1, 4'b0, 4'b0, 0, 1'b0, "R9 clear read returns old values");
        read_page(1'b0, 4'b0, 4'b0, 0, 1'b0, "R9 counters zero after clear read");
    endtask

    task automatic t_collide();
        pulse(4'b0110, 6);
        read_page(1'b1, 4'b1011, 4'b0, 0, 1'b0, "R11 clear read snapshot");
        read_page(1'b0, 4'b0, 4'b0, 0, 1'b0, "R11 event counted after read clear");
        pulse(4'b1111, 9);
        selftest(4'b0100);
        read_page(1'b0, 4'b0, 4'b0, 0, 1'b0, "R10 R11 self-test clear with event");
    endtask

    task automatic t_snapshot();
        pulse(4'b0001, 2);
        read_page(1'b0, 4'b0, 4'b1100, 10, 1'b1, "R12 R8 snapshot with events and extra request");
        read_page(1'b0, 4'b0, 4'b0, 0, 1'b0, "R12 events during stream counted");
    endtask

    task automatic t_saturate();
        selftest(4'b0000);
        pulse(4'b0101, 65540);
        read_page(1'b0, 4'b0, 4'b0, 0, 1'b0, "R3 16-bit saturates, 32-bit keeps counting");
        chk(got[1] == 16'hFFFF, "R3 CRC counter held at max", {48'd0, got[1]}, 64'hFFFF);
        chk({got[6], got[5]} == 32'd65540, "R3 wide counter no truncation",
            {32'd0, got[6], got[5]}, 64'd65540);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_v[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_readclr();
        t_collide();
        t_snapshot();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<195000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule